// File: doc/BRIEF.md
# Circular Frame Buffer Sequence Checker

This block watches the stream of accesses made to a set of twelve virtual circular frame buffers. It judges each one as it happens: a write or read must move through its buffer in forward raster-scan order. Two kinds of address change are tolerated. The first is free movement inside the slice that is already in use, which absorbs small variations in line width. The second is a jump back to the buffer's first location when the frame-start flag is raised. Any access that lands in an earlier slice, lies outside its buffer window, names a buffer that does not exist, or raises frame start away from the base is a sequence error.

Each buffer has its own base address, inclusive last address and slice size, given as a power-of-two shift. The block reaches its verdict combinationally in the cycle of the strobe. A legal write is passed on through the write enable. A failing read is marked with a data-invalid flag. Write and read traffic keep independent slice trackers. A failing access leaves its tracker untouched. It also sets a sticky per-buffer bit in the write-error map or the read-error map. These maps feed two bits of a raw interrupt vector. All sticky state is cleared through write-one-to-clear masks.

Top module: `cfb_seq_checker`

## Requirements
- R1: A non-frame-start access whose slice index, (address − base) >> shift, is greater than or equal to the tracked slice is legal, and the tracker moves to that slice.
- R2: Accesses in any address order inside the currently tracked slice are legal.
- R3: A non-frame-start access to a slice below the tracked one is an error: acc_ok_o is 0, wr_en_o stays 0 for a write, and rd_inval_o is 1 for a read, all in the cycle of the strobe.
- R4: A frame-start access to exactly the buffer base is legal and resets the tracker to slice 0; a frame-start access to any other address is an error.
- R5: An address below the base or above the last address of its buffer, or a buffer index of 12 or more, is an error.
- R6: An erroring access leaves the tracked slice of its buffer and direction unchanged.
- R7: Writes and reads keep separate trackers for each buffer, so that traffic in one direction never changes the verdict for the other.
- R8: After the clock edge that ends an erroring access to buffer i < 12, bit i of wr_err_o (writes) or rd_err_o (reads) is 1 and stays set. Both maps are 0 after reset.
- R9: irq_raw_o bit 7 is 1 whenever any wr_err_o bit is set, bit 10 is 1 whenever any rd_err_o bit is set, and all other irq_raw_o bits are 0.
- R10: A 1 in wr_err_clr_i, rd_err_clr_i or irq_clr_i clears the matching sticky bit at the next edge. A new error that sets the same bit in the same cycle wins over the clear.
- R11: While acc_valid_i is 0 the block raises no enable, no invalid flag and no error bit, whatever the other access inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| acc_valid_i | input | 1 | Access strobe |
| acc_write_i | input | 1 | 1 = write, 0 = read |
| acc_frame_i | input | 1 | Frame-start flag for this access |
| acc_buf_i | input | 4 | Buffer index (0 to 11 valid) |
| acc_addr_i | input | 16 | Virtual address |
| cfg_base_i | input | 12×16 | Base address per buffer |
| cfg_last_i | input | 12×16 | Inclusive last address per buffer |
| cfg_shift_i | input | 12×4 | log2 of slice size per buffer |
| wr_err_clr_i | input | 12 | Write-one-to-clear mask for the write-error map |
| rd_err_clr_i | input | 12 | Write-one-to-clear mask for the read-error map |
| irq_clr_i | input | 16 | Write-one-to-clear mask for the raw interrupt bits |
| acc_ok_o | output | 1 | Combinational verdict: 1 = legal |
| wr_en_o | output | 1 | Write allowed to proceed |
| rd_inval_o | output | 1 | Read data must be treated as invalid |
| wr_err_o | output | 12 | Sticky write sequence-error map, one bit per buffer |
| rd_err_o | output | 12 | Sticky read sequence-error map, one bit per buffer |
| irq_raw_o | output | 16 | Raw interrupt vector (bit 7 write, bit 10 read) |

## Verification
On every cycle, the assertions hold the following. A tracked slice never moves backwards except through a frame-start update, and it holds still when no update is applied. A newly set error bit must trace back to a failed access of the matching direction. A set that meets a clear in the same cycle ends up set. Each raw interrupt bit covers its whole error map. The enable and the invalid flag are never both raised. Only the bench's sequences can show which addresses count as legal. These include slice skipping, frame-start returns to the base and to other addresses, window and index limits, the state left alone after an error, and read/write independence. Each of these depends on a history of earlier accesses that a single-cycle property cannot rebuild.

// File: rtl/cfbsc_pkg.sv
package cfbsc_pkg;

    parameter int NUM_BUF    = 12;
    parameter int ADDR_W     = 16;
    parameter int IRQ_W      = 16;
    parameter int IRQ_WR_BIT = 7;
    parameter int IRQ_RD_BIT = 10;

    // Why an access was rejected (or not)
    typedef enum logic [2:0] {
        VERD_OK    = 3'd0,
        VERD_BACK  = 3'd1,
        VERD_RANGE = 3'd2,
        VERD_FRAME = 3'd3,
        VERD_INDEX = 3'd4
    } verdict_e;

    typedef struct packed {
        verdict_e code;
        logic     pass;
    } verdict_t;

    function automatic verdict_t make_verdict(verdict_e c);
        verdict_t v;
        v.code = c;
        v.pass = (c == VERD_OK);
        return v;
    endfunction

endpackage

// File: rtl/cfbsc_rule.sv
module cfbsc_rule
    import cfbsc_pkg::*;
#(
    parameter int ADDR_W  = cfbsc_pkg::ADDR_W,
    parameter int SHIFT_W = $clog2(ADDR_W)
) (
    input  logic               idx_ok_i,
    input  logic               frame_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [ADDR_W-1:0]  base_i,
    input  logic [ADDR_W-1:0]  last_i,
    input  logic [SHIFT_W-1:0] shift_i,
    input  logic [ADDR_W-1:0]  cur_slice_i,
    output verdict_t           verdict_o,
    output logic [ADDR_W-1:0]  next_slice_o
);

    logic [ADDR_W-1:0] offset;
    logic [ADDR_W-1:0] slice;
    logic              in_window;

    assign offset    = addr_i - base_i;
    assign slice     = offset >> shift_i;
    assign in_window = (addr_i >= base_i) && (addr_i <= last_i);

    always_comb begin
        next_slice_o = cur_slice_i;
        if (!idx_ok_i) begin
            verdict_o = make_verdict(VERD_INDEX);
        end else if (!in_window) begin
            verdict_o = make_verdict(VERD_RANGE);
        end else if (frame_i) begin
            if (addr_i == base_i) begin
                verdict_o    = make_verdict(VERD_OK);
                next_slice_o = '0;
            end else begin
                verdict_o = make_verdict(VERD_FRAME);
            end
        end else if (slice < cur_slice_i) begin
            verdict_o = make_verdict(VERD_BACK);
        end else begin
            verdict_o    = make_verdict(VERD_OK);
            next_slice_o = slice;
        end
    end

endmodule

// File: rtl/cfbsc_tracker.sv
module cfbsc_tracker #(
    parameter int NUM_BUF = cfbsc_pkg::NUM_BUF,
    parameter int ADDR_W  = cfbsc_pkg::ADDR_W,
    parameter int IDX_W   = $clog2(NUM_BUF)
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              upd_i,
    input  logic              frame_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [ADDR_W-1:0] slice_i,
    output logic [ADDR_W-1:0] cur_o
);

    logic [ADDR_W-1:0] cur_q [NUM_BUF];

    for (genvar g = 0; g < NUM_BUF; g++) begin : g_buf
        always_ff @(posedge clk_i) begin
            if (rst_i) begin
                cur_q[g] <= '0;
            end else if (upd_i && (idx_i == IDX_W'(g))) begin
                cur_q[g] <= slice_i;
            end
        end

        // R1
        slice_fwd_chk: assert property (@(posedge clk_i) disable iff (rst_i)
            !(upd_i && frame_i && (idx_i == IDX_W'(g))) |=> (cur_q[g] >= $past(cur_q[g])));

        // R6
        slice_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
            !upd_i |=> $stable(cur_q[g]));
    end : g_buf

    always_comb begin
        cur_o = '0;
        for (int i = 0; i < NUM_BUF; i++) begin
            if (idx_i == IDX_W'(i)) cur_o = cur_q[i];
        end
    end

endmodule

// File: rtl/cfbsc_err_bank.sv
module cfbsc_err_bank #(
    parameter int NUM_BUF = cfbsc_pkg::NUM_BUF
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic [NUM_BUF-1:0] set_i,
    input  logic [NUM_BUF-1:0] clr_i,
    output logic [NUM_BUF-1:0] map_o,
    output logic               any_next_o
);

    logic [NUM_BUF-1:0] map_q;
    logic [NUM_BUF-1:0] map_d;

    assign map_d      = (map_q & ~clr_i) | set_i;
    assign any_next_o = |map_d;
    assign map_o      = map_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) map_q <= '0;
        else       map_q <= map_d;
    end

    // R10
    set_wins_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (|set_i) |=> ((map_o & $past(set_i)) == $past(set_i)));

endmodule

// File: rtl/cfb_seq_checker.sv
module cfb_seq_checker
    import cfbsc_pkg::*;
#(
    parameter int NUM_BUF    = cfbsc_pkg::NUM_BUF,
    parameter int ADDR_W     = cfbsc_pkg::ADDR_W,
    parameter int IRQ_W      = cfbsc_pkg::IRQ_W,
    parameter int IRQ_WR_BIT = cfbsc_pkg::IRQ_WR_BIT,
    parameter int IRQ_RD_BIT = cfbsc_pkg::IRQ_RD_BIT,
    localparam int IDX_W     = $clog2(NUM_BUF),
    localparam int SHIFT_W   = $clog2(ADDR_W)
) (
    input  logic                            clk_i,
    input  logic                            rst_i,
    input  logic                            acc_valid_i,
    input  logic                            acc_write_i,
    input  logic                            acc_frame_i,
    input  logic [IDX_W-1:0]                acc_buf_i,
    input  logic [ADDR_W-1:0]               acc_addr_i,
    input  logic [NUM_BUF-1:0][ADDR_W-1:0]  cfg_base_i,
    input  logic [NUM_BUF-1:0][ADDR_W-1:0]  cfg_last_i,
    input  logic [NUM_BUF-1:0][SHIFT_W-1:0] cfg_shift_i,
    input  logic [NUM_BUF-1:0]              wr_err_clr_i,
    input  logic [NUM_BUF-1:0]              rd_err_clr_i,
    input  logic [IRQ_W-1:0]                irq_clr_i,
    output logic                            acc_ok_o,
    output logic                            wr_en_o,
    output logic                            rd_inval_o,
    output logic [NUM_BUF-1:0]              wr_err_o,
    output logic [NUM_BUF-1:0]              rd_err_o,
    output logic [IRQ_W-1:0]                irq_raw_o
);

    localparam int NUM_DIR = 2;   // index 0 = write, 1 = read

    // ---- per-buffer configuration select ----
    logic               idx_ok;
    logic [NUM_BUF-1:0] sel_oh;
    logic [ADDR_W-1:0]  base_s;
    logic [ADDR_W-1:0]  last_s;
    logic [SHIFT_W-1:0] shift_s;

    always_comb begin
        idx_ok  = 1'b0;
        sel_oh  = '0;
        base_s  = '0;
        last_s  = '0;
        shift_s = '0;
        for (int i = 0; i < NUM_BUF; i++) begin
            if (acc_buf_i == IDX_W'(i)) begin
                idx_ok    = 1'b1;
                sel_oh[i] = 1'b1;
                base_s    = cfg_base_i[i];
                last_s    = cfg_last_i[i];
                shift_s   = cfg_shift_i[i];
            end
        end
    end

    // ---- per-direction state ----
    logic [ADDR_W-1:0]  cur_dir  [NUM_DIR];
    logic [NUM_BUF-1:0] map_dir  [NUM_DIR];
    logic               any_next [NUM_DIR];
    logic [ADDR_W-1:0]  cur_slice;
    logic [ADDR_W-1:0]  next_slice;
    verdict_t           verdict;

    assign cur_slice = acc_write_i ? cur_dir[0] : cur_dir[1];

    cfbsc_rule #(
        .ADDR_W  (ADDR_W),
        .SHIFT_W (SHIFT_W)
    ) u_rule (
        .idx_ok_i     (idx_ok),
        .frame_i      (acc_frame_i),
        .addr_i       (acc_addr_i),
        .base_i       (base_s),
        .last_i       (last_s),
        .shift_i      (shift_s),
        .cur_slice_i  (cur_slice),
        .verdict_o    (verdict),
        .next_slice_o (next_slice)
    );

    for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
        localparam logic IS_WR = (d == 0);
        logic               hit;
        logic               upd;
        logic [NUM_BUF-1:0] set;
        logic [NUM_BUF-1:0] clr;

        assign hit = acc_valid_i && (acc_write_i == IS_WR);
        assign upd = hit && verdict.pass;
        assign set = (hit && !verdict.pass) ? sel_oh : '0;

        if (d == 0) begin : g_wclr
            assign clr = wr_err_clr_i;
        end else begin : g_rclr
            assign clr = rd_err_clr_i;
        end

        cfbsc_tracker #(
            .NUM_BUF (NUM_BUF),
            .ADDR_W  (ADDR_W),
            .IDX_W   (IDX_W)
        ) u_trk (
            .clk_i   (clk_i),
            .rst_i   (rst_i),
            .upd_i   (upd),
            .frame_i (acc_frame_i),
            .idx_i   (acc_buf_i),
            .slice_i (next_slice),
            .cur_o   (cur_dir[d])
        );

        cfbsc_err_bank #(
            .NUM_BUF (NUM_BUF)
        ) u_err (
            .clk_i      (clk_i),
            .rst_i      (rst_i),
            .set_i      (set),
            .clr_i      (clr),
            .map_o      (map_dir[d]),
            .any_next_o (any_next[d])
        );
    end : g_dir

    // ---- raw interrupt vector ----
    logic [IRQ_W-1:0] irq_q;

    for (genvar b = 0; b < IRQ_W; b++) begin : g_irq
        logic src;
        if (b == IRQ_WR_BIT) begin : g_w
            assign src = any_next[0];
        end else if (b == IRQ_RD_BIT) begin : g_r
            assign src = any_next[1];
        end else begin : g_z
            assign src = 1'b0;
        end

        always_ff @(posedge clk_i) begin
            if (rst_i) irq_q[b] <= 1'b0;
            else       irq_q[b] <= (irq_q[b] & ~irq_clr_i[b]) | src;
        end
    end : g_irq

    // ---- outputs ----
    assign acc_ok_o   = verdict.pass;
    assign wr_en_o    = acc_valid_i && acc_write_i && verdict.pass;
    assign rd_inval_o = acc_valid_i && !acc_write_i && !verdict.pass;
    assign wr_err_o   = map_dir[0];
    assign rd_err_o   = map_dir[1];
    assign irq_raw_o  = irq_q;

    // R8
    wr_err_src_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (|(wr_err_o & ~$past(wr_err_o))) |-> $past(acc_valid_i && acc_write_i && !acc_ok_o));

    // R8
    rd_err_src_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (|(rd_err_o & ~$past(rd_err_o))) |-> $past(acc_valid_i && !acc_write_i && !acc_ok_o));

    // R9
    irq_wr_cover_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (|wr_err_o) |-> irq_raw_o[IRQ_WR_BIT]);

    // R9
    irq_rd_cover_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (|rd_err_o) |-> irq_raw_o[IRQ_RD_BIT]);

    // R11
    idle_quiet_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !acc_valid_i |=> (((wr_err_o & ~$past(wr_err_o)) == '0) && ((rd_err_o & ~$past(rd_err_o)) == '0)));

    // R3
    en_inval_excl_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0({wr_en_o, rd_inval_o}));

endmodule

// File: tb/test_cfb_seq_checker.sv
`timescale 1ns/1ps
module test_cfb_seq_checker;

    localparam int NB = 12;
    localparam int AW = 16;
    localparam int IW = 4;
    localparam int SW = 4;

    typedef struct packed {
        logic [IW-1:0] bidx;
        logic [AW-1:0] addr;
        logic          wr;
        logic          fs;
        logic          ok;
        logic [3:0]    req;
    } vec_t;

    // Buffer b: base 0x1000*(b+1), last base+0xFFF, slice shift 6+(b%3)
    localparam int NV = 23;
    localparam vec_t VECS [NV] = '{
        '{4'd0,  16'h1000, 1'b1, 1'b1, 1'b1, 4'd4},  // R4 frame start at base
        '{4'd0,  16'h1030, 1'b1, 1'b0, 1'b1, 4'd1},  // R1
        '{4'd0,  16'h1010, 1'b1, 1'b0, 1'b1, 4'd2},  // R2 random inside slice 0
        '{4'd0,  16'h1050, 1'b1, 1'b0, 1'b1, 4'd1},  // R1 slice 1
        '{4'd0,  16'h1100, 1'b1, 1'b0, 1'b1, 4'd1},  // R1 skip to slice 4
        '{4'd0,  16'h10C0, 1'b1, 1'b0, 1'b0, 4'd3},  // R3 back to slice 3
        '{4'd0,  16'h1110, 1'b1, 1'b0, 1'b1, 4'd2},  // R2
        '{4'd0,  16'h1000, 1'b1, 1'b0, 1'b0, 4'd3},  // R3 base without frame start
        '{4'd0,  16'h1040, 1'b1, 1'b1, 1'b0, 4'd4},  // R4 frame start off base
        '{4'd0,  16'h1010, 1'b1, 1'b0, 1'b0, 4'd6},  // R6 tracker still at 4
        '{4'd0,  16'h2000, 1'b1, 1'b0, 1'b0, 4'd5},  // R5 above window
        '{4'd0,  16'h1120, 1'b1, 1'b0, 1'b1, 4'd6},  // R6 tracker not moved to 64
        '{4'd0,  16'h0FFF, 1'b1, 1'b0, 1'b0, 4'd5},  // R5 below window
        '{4'd0,  16'h1000, 1'b1, 1'b1, 1'b1, 4'd4},  // R4 new frame
        '{4'd0,  16'h1010, 1'b1, 1'b0, 1'b1, 4'd2},  // R2
        '{4'd0,  16'h1040, 1'b0, 1'b0, 1'b1, 4'd7},  // R7 read tracker own
        '{4'd0,  16'h1000, 1'b0, 1'b0, 1'b0, 4'd3},  // R3 read goes back
        '{4'd0,  16'h1045, 1'b0, 1'b0, 1'b1, 4'd7},  // R7
        '{4'd0,  16'h1020, 1'b1, 1'b0, 1'b1, 4'd7},  // R7 write still slice 0
        '{4'd2,  16'h3250, 1'b1, 1'b0, 1'b1, 4'd1},  // R1 buffer 2 slice 2
        '{4'd2,  16'h3100, 1'b1, 1'b0, 1'b0, 4'd3},  // R3
        '{4'd2,  16'h32FF, 1'b1, 1'b0, 1'b1, 4'd2},  // R2
        '{4'd13, 16'h1000, 1'b1, 1'b1, 1'b0, 4'd5}   // R5 index out of range
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic acc_valid = 1'b0, acc_write = 1'b0, acc_frame = 1'b0;
    logic [IW-1:0] acc_buf = '0;
    logic [AW-1:0] acc_addr = '0;
    logic [NB-1:0][AW-1:0] cfg_base, cfg_last;
    logic [NB-1:0][SW-1:0] cfg_shift;
    logic [NB-1:0] wclr = '0, rclr = '0;
    logic [15:0]   iclr = '0;
    logic acc_ok, wr_en, rd_inval;
    logic [NB-1:0] wr_err, rd_err;
    logic [15:0]   irq_raw;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    cfb_seq_checker i_cfb_seq_checker (
        .clk_i (clk), .rst_i (rst),
        .acc_valid_i (acc_valid), .acc_write_i (acc_write), .acc_frame_i (acc_frame),
        .acc_buf_i (acc_buf), .acc_addr_i (acc_addr),
        .cfg_base_i (cfg_base), .cfg_last_i (cfg_last), .cfg_shift_i (cfg_shift),
        .wr_err_clr_i (wclr), .rd_err_clr_i (rclr), .irq_clr_i (iclr),
        .acc_ok_o (acc_ok), .wr_en_o (wr_en), .rd_inval_o (rd_inval),
        .wr_err_o (wr_err), .rd_err_o (rd_err), .irq_raw_o (irq_raw)
    );

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Drive one cycle of inputs at the falling edge; comb outputs are valid 1 ns later
    task automatic drive(logic v, logic w, logic f, logic [IW-1:0] b, logic [AW-1:0] a,
                         logic [NB-1:0] wc, logic [NB-1:0] rc, logic [15:0] ic);
        @(negedge clk);
        acc_valid = v; acc_write = w; acc_frame = f; acc_buf = b; acc_addr = a;
        wclr = wc; rclr = rc; iclr = ic;
        #1;
    endtask

    task automatic finish_cycle();
        @(posedge clk);
        #1;
        acc_valid = 1'b0; wclr = '0; rclr = '0; iclr = '0;
    endtask

    initial begin
        for (int b = 0; b < NB; b++) begin
            cfg_base[b]  = AW'(16'h1000 * (b + 1));
            cfg_last[b]  = AW'(16'h1000 * (b + 1) + 16'h0FFF);
            cfg_shift[b] = SW'(6 + (b % 3));
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R8 reset state
        check("R8", "wr_err after reset", 32'(wr_err), 32'h0);
        check("R8", "rd_err after reset", 32'(rd_err), 32'h0);
        check("R9", "irq after reset", 32'(irq_raw), 32'h0);

        // R11 no strobe: bad access pattern must have no effect
        drive(1'b0, 1'b1, 1'b0, 4'd5, 16'h0000, '0, '0, '0);
        check("R11", "wr_en idle", 32'(wr_en), 32'h0);
        check("R11", "rd_inval idle", 32'(rd_inval), 32'h0);
        finish_cycle();
        check("R11", "wr_err idle", 32'(wr_err), 32'h0);
        drive(1'b0, 1'b0, 1'b0, 4'd5, 16'h0000, '0, '0, '0);
        check("R11", "rd_inval idle read", 32'(rd_inval), 32'h0);
        finish_cycle();
        check("R11", "rd_err idle", 32'(rd_err), 32'h0);

        for (int n = 0; n < NV; n++) begin
            automatic vec_t v = VECS[n];
            automatic string r = $sformatf("R%0d", v.req);
            drive(1'b1, v.wr, v.fs, v.bidx, v.addr, '0, '0, '0);
            check(r, $sformatf("vec %0d acc_ok", n), 32'(acc_ok), 32'(v.ok));
            check(r, $sformatf("vec %0d wr_en", n), 32'(wr_en), 32'(v.wr & v.ok));
            check(r, $sformatf("vec %0d rd_inval", n), 32'(rd_inval), 32'(!v.wr & !v.ok));
            finish_cycle();
            if (!v.ok && v.bidx < IW'(NB)) begin
                if (v.wr) check("R8", $sformatf("vec %0d wr_err bit", n), 32'(wr_err[v.bidx]), 32'h1);
                else      check("R8", $sformatf("vec %0d rd_err bit", n), 32'(rd_err[v.bidx]), 32'h1);
            end
        end

        // R8 sticky maps, R5 index 13 set nothing
        check("R8", "wr_err map after table", 32'(wr_err), 32'h005);
        check("R8", "rd_err map after table", 32'(rd_err), 32'h001);
        check("R9", "irq after table", 32'(irq_raw), 32'h0480);

        // R10 partial clear of write map
        drive(1'b0, 1'b0, 1'b0, 4'd0, 16'h0000, 12'h001, '0, '0);
        finish_cycle();
        check("R10", "wr_err after clearing bit 0", 32'(wr_err), 32'h004);
        check("R9", "irq bit 7 still up", 32'(irq_raw), 32'h0480);

        // R10 clear last write bit and irq bit 7 together
        drive(1'b0, 1'b0, 1'b0, 4'd0, 16'h0000, 12'h004, '0, 16'h0080);
        finish_cycle();
        check("R10", "wr_err cleared", 32'(wr_err), 32'h000);
        check("R9", "irq bit 7 cleared", 32'(irq_raw), 32'h0400);

        // R10 new read error on buffer 0 beats simultaneous clear
        drive(1'b1, 1'b0, 1'b0, 4'd0, 16'h1000, '0, 12'h001, 16'h0400);
        check("R3", "rd_inval on backward read", 32'(rd_inval), 32'h1);
        finish_cycle();
        check("R10", "rd_err set wins over clear", 32'(rd_err), 32'h001);
        check("R10", "irq bit 10 set wins", 32'(irq_raw), 32'h0400);

        // R9 final clear of read map and irq bit 10
        drive(1'b0, 1'b0, 1'b0, 4'd0, 16'h0000, '0, 12'h001, 16'h0400);
        finish_cycle();
        check("R10", "rd_err cleared", 32'(rd_err), 32'h000);
        check("R9", "irq all clear", 32'(irq_raw), 32'h0000);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule